// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a bus-mapped watchdog. Slow-clock enable pulses are divided by a prescaler, and each prescaler tick moves a 12-bit down-counter one step. With the default divide of 128 and a 32.768 kHz slow clock, the counter steps at 256 Hz. The longest period is 4096 ticks, about 16 seconds. A period of s seconds is programmed as s*256-1 in the reload field.

If the counter passes zero, the block records an underflow fault, raises its interrupt and, if enabled, sends a one-cycle reset request to the system reset controller. Software restarts the counter by writing a command word that carries a key byte. A restart is accepted only while the count is at or below a programmed window limit. A keyed restart that comes too early is recorded as a window fault and is treated like an underflow.

The mode word sets the reload value, the window limit, reset enable, debug freeze and disable. It accepts only the first write after reset, so a runaway program cannot turn the watchdog off afterwards.

Top module: `wdt_window_top`

## Requirements
- R1: Out of reset the MODE word (word 1) reads 0x0FFF1FFF, COUNT (word 3, bits 11:0) reads 0xFFF, STATUS (word 2) reads 0, and both `wdt_rst_o` and `wdt_irq_o` are low. The MODE layout is: reload in bits 11:0, reset enable in bit 12, debug freeze in bit 13, disable in bit 14, and window limit in bits 27:16.
- R2: The counter steps down once for every DIV cycles with `slow_tick_i` high. Cycles with `slow_tick_i` low do not advance it.
- R3: The first MODE write loads the counter with the new reload value and clears the prescaler. Counting one step below zero is an underflow: it sets STATUS bit 0 and reloads the counter. With reload R, this happens DIV*(R+1) slow ticks after the write.
- R4: Every fault (an underflow or a window fault) drives `wdt_rst_o` high for exactly one cycle when MODE bit 12 is set. When bit 12 is clear, the reset request is never driven. `wdt_irq_o` is high while any STATUS bit is set.
- R5: Only the first MODE write after reset takes effect. Later writes are ignored, including a write that sets the disable bit.
- R6: While MODE bit 14 is set, the counter holds its value, restarts have no effect, and no fault or reset request occurs.
- R7: While MODE bit 13 is set and `dbg_halt_i` is high, the counter and prescaler hold. With bit 13 clear, `dbg_halt_i` is ignored.
- R8: A write to CMD (word 0) with bit 0 set and key 0xA5 in bits 31:24 reloads the counter and clears the prescaler. A wrong key, or bit 0 clear, has no effect.
- R9: A keyed restart while the count is above the window limit is a window fault. It sets STATUS bit 1 and leaves the counter as it was. A keyed restart at or below the limit raises no fault.
- R10: Reading STATUS returns the flags and clears them. A flag that sets in the same cycle as the read stays set.
- R11: An accepted restart in the same cycle as the tick that would underflow wins: the counter reloads and no underflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Byte address; bits 3:2 select the word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the read strobe |
| slow_tick_i | input | 1 | Slow-clock enable pulse |
| dbg_halt_i | input | 1 | Debugger halt indication |
| wdt_rst_o | output | 1 | One-cycle system reset request |
| wdt_irq_o | output | 1 | Fault interrupt, level |

## Verification
Two pairs of events can meet in one cycle.

- Restart and underflow: a keyed restart is written so that it lands on exactly the prescaler tick that would take the counter past zero. The design passes if no reset request appears, STATUS stays clear and the counter reads back the reload value.
- STATUS read and new underflow: a STATUS read is timed onto the underflow edge. The design passes if that read returns the old flags and a second read shows the underflow flag still set.

The bench works out both edges by counting prescaler ticks from the MODE write.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 32;

    // word selected by bus_addr_i[3:2]
    typedef enum logic [1:0] {
        REG_CMD  = 2'd0,
        REG_MODE = 2'd1,
        REG_STAT = 2'd2,
        REG_CNT  = 2'd3
    } reg_sel_e;

    localparam logic [7:0] RESTART_KEY = 8'hA5;
    localparam int KEY_LSB       = 24;
    localparam int CMD_GO_BIT    = 0;
    localparam int MODE_RST_BIT  = 12;
    localparam int MODE_DBG_BIT  = 13;
    localparam int MODE_OFF_BIT  = 14;
    localparam int MODE_WIN_LSB  = 16;
    localparam int STAT_UF_BIT   = 0;
    localparam int STAT_WERR_BIT = 1;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_tick_i,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        pre_d  = pre_q;
        tick_o = run_i && slow_tick_i && (pre_q == LAST);
        if (clr_i) begin
            pre_d = '0;
        end else if (run_i && slow_tick_i) begin
            pre_d = (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end
endmodule

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
    import wdt_pkg::*;
(
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output reg_sel_e          sel_o,
    output logic              mode_wr_o,
    output logic              restart_o,
    output logic              stat_rd_o
);
    always_comb begin
        sel_o     = reg_sel_e'(addr_i[3:2]);
        mode_wr_o = wr_i && (sel_o == REG_MODE);
        restart_o = wr_i && (sel_o == REG_CMD)
                    && wdata_i[CMD_GO_BIT]
                    && (wdata_i[KEY_LSB +: 8] == RESTART_KEY);
        stat_rd_o = rd_i && (sel_o == REG_STAT);
    end
endmodule

// File: rtl/wdt_window_top.sv
module wdt_window_top
    import wdt_pkg::*;
#(
    parameter int CNT_W = 12,
    parameter int DIV   = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bus_rvalid_o,
    input  logic              slow_tick_i,
    input  logic              dbg_halt_i,
    output logic              wdt_rst_o,
    output logic              wdt_irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  delta;
        logic              rst_en;
        logic              dbg_en;
        logic              off;
        logic              locked;
        logic [CNT_W-1:0]  cnt;
        logic              uf;
        logic              werr;
        logic              rst_pls;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } state_t;

    state_t   s_d, s_q;
    reg_sel_e sel;
    logic     mode_wr, restart, stat_rd;
    logic     tick, run, pre_clr;
    logic     mode_take, restart_ok, win_err, uf_evt;

    wdt_bus_decode u_dec (
        .wr_i      (bus_wr_i),
        .rd_i      (bus_rd_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .sel_o     (sel),
        .mode_wr_o (mode_wr),
        .restart_o (restart),
        .stat_rd_o (stat_rd)
    );

    wdt_prescaler #(.DIV(DIV)) u_pre (
        .clk         (clk),
        .rst_n       (rst_n),
        .slow_tick_i (slow_tick_i),
        .run_i       (run),
        .clr_i       (pre_clr),
        .tick_o      (tick)
    );

    always_comb begin
        run        = !s_q.off && !(s_q.dbg_en && dbg_halt_i);
        mode_take  = mode_wr && !s_q.locked;
        restart_ok = restart && !s_q.off && (s_q.cnt <= s_q.delta);
        win_err    = restart && !s_q.off && (s_q.cnt > s_q.delta);
        // an accepted restart outranks the underflow tick
        uf_evt     = tick && (s_q.cnt == '0) && !restart_ok;
        pre_clr    = mode_take || restart_ok;

        s_d         = s_q;
        s_d.rst_pls = (uf_evt || win_err) && s_q.rst_en;
        s_d.rvalid  = bus_rd_i;
        s_d.rdata   = '0;

        if (bus_rd_i) begin
            unique case (sel)
                REG_MODE: begin
                    s_d.rdata[CNT_W-1:0]                 = s_q.reload;
                    s_d.rdata[MODE_WIN_LSB +: CNT_W]     = s_q.delta;
                    s_d.rdata[MODE_RST_BIT]              = s_q.rst_en;
                    s_d.rdata[MODE_DBG_BIT]              = s_q.dbg_en;
                    s_d.rdata[MODE_OFF_BIT]              = s_q.off;
                end
                REG_STAT: begin
                    s_d.rdata[STAT_UF_BIT]   = s_q.uf;
                    s_d.rdata[STAT_WERR_BIT] = s_q.werr;
                end
                REG_CNT:  s_d.rdata[CNT_W-1:0] = s_q.cnt;
                default:  s_d.rdata = '0;
            endcase
        end

        if (mode_take) begin
            s_d.reload = bus_wdata_i[CNT_W-1:0];
            s_d.delta  = bus_wdata_i[MODE_WIN_LSB +: CNT_W];
            s_d.rst_en = bus_wdata_i[MODE_RST_BIT];
            s_d.dbg_en = bus_wdata_i[MODE_DBG_BIT];
            s_d.off    = bus_wdata_i[MODE_OFF_BIT];
            s_d.locked = 1'b1;
            s_d.cnt    = bus_wdata_i[CNT_W-1:0];
        end else if (restart_ok) begin
            s_d.cnt = s_q.reload;
        end else if (tick) begin
            s_d.cnt = (s_q.cnt == '0) ? s_q.reload : s_q.cnt - 1'b1;
        end

        // clear on read first, so a flag set in the same cycle survives
        if (stat_rd) begin
            s_d.uf   = 1'b0;
            s_d.werr = 1'b0;
        end
        if (uf_evt)  s_d.uf   = 1'b1;
        if (win_err) s_d.werr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.reload <= '1;
            s_q.delta  <= '1;
            s_q.rst_en <= 1'b1;
            s_q.cnt    <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata_o  = s_q.rdata;
    assign bus_rvalid_o = s_q.rvalid;
    assign wdt_rst_o    = s_q.rst_pls;
    assign wdt_irq_o    = s_q.uf || s_q.werr;
endmodule

// File: rtl/wdt_window_chk.sv
module wdt_window_chk #(
    parameter int CNT_W = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               slow_tick,
    input logic               wr_en,
    input logic               stat_rd,
    input logic               dbg_halt,
    input logic               locked,
    input logic               off,
    input logic               dbg_en,
    input logic [2*CNT_W+2:0] mode_bits,
    input logic [CNT_W-1:0]   cnt,
    input logic               werr,
    input logic               rst_o,
    input logic               irq_o
);
    AST_STALL_NO_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_tick && !wr_en) |=> $stable(cnt)); // R2

    AST_RST_FLAGS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |-> irq_o); // R4

    AST_MODE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(mode_bits))); // R5

    AST_OFF_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && off) |=> !rst_o); // R6

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && off) |=> $stable(cnt)); // R6

    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && dbg_halt && !wr_en) |=> $stable(cnt)); // R7

    AST_WERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (werr && !stat_rd) |=> werr); // R10
endmodule

bind wdt_window_top wdt_window_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .slow_tick (slow_tick_i),
    .wr_en     (bus_wr_i),
    .stat_rd   (stat_rd),
    .dbg_halt  (dbg_halt_i),
    .locked    (s_q.locked),
    .off       (s_q.off),
    .dbg_en    (s_q.dbg_en),
    .mode_bits ({s_q.reload, s_q.delta, s_q.rst_en, s_q.dbg_en, s_q.off}),
    .cnt       (s_q.cnt),
    .werr      (s_q.werr),
    .rst_o     (wdt_rst_o),
    .irq_o     (wdt_irq_o)
);

// File: tb/tb_wdt_window_top.sv
module tb_wdt_window_top;
    localparam int DIV = 4;
    localparam logic [31:0] KEYGO = 32'hA500_0001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        slow_tick = 1'b0, dbg_halt = 1'b0;
    logic        wdt_rst, wdt_irq;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk; // 125 MHz

    wdt_window_top #(.CNT_W(12), .DIV(DIV)) dut (
        .clk(clk), .rst_n(rst_n),
        .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .bus_rvalid_o(bus_rvalid),
        .slow_tick_i(slow_tick), .dbg_halt_i(dbg_halt),
        .wdt_rst_o(wdt_rst), .wdt_irq_o(wdt_irq)
    );

    function automatic logic [31:0] mode_val(input logic [11:0] rl, input logic [11:0] dl,
                                             input logic rs, input logic dg, input logic of);
        return {4'h0, dl, 1'b0, of, dg, rs, rl};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // monitor: pops the scoreboard on each returned read
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (exp_q.size() == 0) begin
                chk("unexpected read data", bus_rdata, 32'hX);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, bus_rdata, e);
            end
        end
    end

    // driver tasks: called at a negedge, return at the next negedge
    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // ---- R1 reset state, R2 stall ----
        do_reset();
        chk("R1 rst_o after reset", {31'b0, wdt_rst}, 0);
        chk("R1 irq after reset", {31'b0, wdt_irq}, 0);
        rd(4'h4, 32'h0FFF_1FFF, "R1 mode reset value");
        rd(4'hC, 32'h0000_0FFF, "R1 count reset value");
        rd(4'h8, 32'h0, "R1 status reset value");
        slow_tick = 1'b1;
        repeat (8) @(negedge clk);
        rd(4'hC, 32'h0000_0FFD, "R2 two steps after 8 slow ticks");
        slow_tick = 1'b0;
        repeat (10) @(negedge clk);
        rd(4'hC, 32'h0000_0FFD, "R2 no step without slow tick");

        // ---- R3/R4 underflow timing, R7 halt ignored when disabled in mode ----
        do_reset();
        slow_tick = 1'b1;
        dbg_halt  = 1'b1;
        wr(4'h4, mode_val(12'd3, 12'hFFF, 1'b1, 1'b0, 1'b0));
        for (int i = 1; i <= 17; i++) begin
            @(negedge clk);
            if (i == 15) chk("R3 no reset before underflow", {31'b0, wdt_rst}, 0);
            if (i == 16) begin
                chk("R3 R7 reset at underflow (halt bit clear)", {31'b0, wdt_rst}, 1);
                chk("R4 irq at underflow", {31'b0, wdt_irq}, 1);
            end
            if (i == 17) chk("R4 reset pulse one cycle", {31'b0, wdt_rst}, 0);
        end
        dbg_halt = 1'b0;
        rd(4'h8, 32'h1, "R3 underflow flag");
        rd(4'h8, 32'h0, "R10 status cleared by read");
        chk("R10 irq after clear", {31'b0, wdt_irq}, 0);
        // ---- R5 write-once ----
        wr(4'h4, mode_val(12'd5, 12'h010, 1'b0, 1'b1, 1'b1));
        rd(4'h4, mode_val(12'd3, 12'hFFF, 1'b1, 1'b0, 1'b0), "R5 second mode write ignored");

        // ---- R8 keyed restart ----
        do_reset();
        slow_tick = 1'b1;
        wr(4'h4, mode_val(12'h020, 12'hFFF, 1'b1, 1'b0, 1'b0));
        repeat (20) @(negedge clk);
        slow_tick = 1'b0;
        rd(4'hC, 32'd27, "R2 five steps in 20 ticks");
        wr(4'h0, 32'h5A00_0001);
        rd(4'hC, 32'd27, "R8 wrong key ignored");
        wr(4'h0, 32'hA500_0000);
        rd(4'hC, 32'd27, "R8 missing restart bit ignored");
        wr(4'h0, KEYGO);
        rd(4'hC, 32'd32, "R8 keyed restart reloads");
        rd(4'h8, 32'h0, "R9 no window fault with open window");

        // ---- R9 window fault ----
        do_reset();
        wr(4'h4, mode_val(12'h020, 12'h010, 1'b1, 1'b0, 1'b0));
        wr(4'h0, KEYGO);
        chk("R9 R4 reset on early restart", {31'b0, wdt_rst}, 1);
        chk("R9 irq on early restart", {31'b0, wdt_irq}, 1);
        rd(4'hC, 32'd32, "R9 counter kept");
        rd(4'h8, 32'h2, "R9 window flag");
        slow_tick = 1'b1;
        repeat (64) @(negedge clk);
        slow_tick = 1'b0;
        rd(4'hC, 32'd16, "R9 count at window limit");
        wr(4'h0, KEYGO);
        chk("R9 no reset inside window", {31'b0, wdt_rst}, 0);
        rd(4'hC, 32'd32, "R9 restart inside window reloads");
        rd(4'h8, 32'h0, "R9 no flag inside window");

        // ---- R4 reset disabled ----
        do_reset();
        wr(4'h4, mode_val(12'h020, 12'h010, 1'b0, 1'b0, 1'b0));
        wr(4'h0, KEYGO);
        chk("R4 no reset when disabled in mode", {31'b0, wdt_rst}, 0);
        chk("R4 irq still raised", {31'b0, wdt_irq}, 1);
        rd(4'h8, 32'h2, "R4 window flag without reset");

        // ---- R6 disable ----
        do_reset();
        slow_tick = 1'b1;
        wr(4'h4, mode_val(12'd2, 12'hFFF, 1'b1, 1'b0, 1'b1));
        begin
            logic seen = 1'b0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (wdt_rst) seen = 1'b1;
            end
            chk("R6 no reset while disabled", {31'b0, seen}, 0);
        end
        rd(4'hC, 32'd2, "R6 counter held");
        rd(4'h8, 32'h0, "R6 no fault flags");
        slow_tick = 1'b0;

        // ---- R7 debug freeze ----
        do_reset();
        slow_tick = 1'b1;
        dbg_halt  = 1'b1;
        wr(4'h4, mode_val(12'h020, 12'hFFF, 1'b1, 1'b1, 1'b0));
        repeat (40) @(negedge clk);
        rd(4'hC, 32'd32, "R7 frozen under halt");
        dbg_halt = 1'b0;
        repeat (8) @(negedge clk);
        rd(4'hC, 32'd30, "R7 resumes after halt");
        slow_tick = 1'b0;

        // ---- R11 restart on the underflow tick ----
        do_reset();
        slow_tick = 1'b1;
        wr(4'h4, mode_val(12'd3, 12'hFFF, 1'b1, 1'b0, 1'b0));
        repeat (15) @(negedge clk);
        wr(4'h0, KEYGO);
        chk("R11 restart beats underflow: no reset", {31'b0, wdt_rst}, 0);
        rd(4'hC, 32'd3, "R11 counter reloaded");
        rd(4'h8, 32'h0, "R11 no underflow flag");

        // ---- R10 read on the set edge ----
        do_reset();
        wr(4'h4, mode_val(12'd3, 12'hFFF, 1'b1, 1'b0, 1'b0));
        repeat (15) @(negedge clk);
        rd(4'h8, 32'h0, "R10 read returns old flags");
        rd(4'h8, 32'h1, "R10 flag set on read edge survives");
        slow_tick = 1'b0;

        repeat (3) @(negedge clk);
        chk("scoreboard drained", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule